// File: doc/BRIEF.md
# Z80 Mode-0 Vectored Interrupt Controller

This block sits on the bus of a Z80 that runs in interrupt mode 0. It takes eight interrupt request lines, ranks them by a fixed priority, and pulls the CPU's INT line low when a request may be served. Each request line has its own 16-bit handler address. Software loads these addresses with I/O writes.

In mode 0 the CPU takes its first instruction byte from the bus during the interrupt acknowledge cycle. The block answers that cycle with a CALL opcode. The CPU then fetches the two operand bytes as ordinary memory reads. The block supplies those bytes itself, low byte first, and raises a memory-inhibit output so that system memory keeps its read drivers off the bus. The inhibit lasts until the CPU's next opcode fetch.

The block remembers which sources are in service. A source in service masks itself and every source of lower priority. It is retired when the block sees the CPU fetch the two-byte return-from-interrupt opcode.

Top module: `z80_im0_vic`

## Requirements
- R1: After reset, with no request asserted, `int_n` is high, `mem_inhibit` is low, `data_oe` is low, all handler addresses read as 0x0000, and no source is in service.
- R2: `int_n` is low exactly when at least one request is eligible and no CALL is being fed. A request is eligible when no source of equal or higher priority is in service.
- R3: Request 0 has the highest priority and request 7 the lowest. The acknowledge serves the highest-priority eligible request.
- R4: While an acknowledge is on the bus (`m1_n` and `iorq_n` both low), the block drives 0xCD with `data_oe` high.
- R5: After an acknowledge, memory reads (`m1_n` high, `mreq_n` and `rd_n` low) return the low byte of the chosen handler address and then its high byte. Any further read before the next opcode fetch is not driven.
- R6: `mem_inhibit` rises on the clock after the acknowledge begins. It falls on the clock after the next opcode fetch (`m1_n` and `mreq_n` low) begins.
- R7: An I/O write (`iorq_n` and `wr_n` low, `m1_n` high) to port BASE+2k loads the low byte of source k's address. A write to port BASE+2k+1 loads its high byte. BASE defaults to 0x40.
- R8: The source served by an acknowledge becomes in service. It then blocks INT for itself and for lower-priority sources, while higher-priority sources can still interrupt.
- R9: An opcode fetch of 0xED followed directly by an opcode fetch of 0x4D retires the highest-priority source in service. A fetch of 0xED followed by any other opcode retires nothing. The fetched byte is the value on `data_in` in the last clock of each fetch.
- R10: The source is latched when the acknowledge begins. Request changes during the feed do not alter the operand bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Interrupt request lines, active high, bit 0 highest priority |
| m1_n | input | 1 | CPU M1 strobe, active low |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| mreq_n | input | 1 | CPU memory request strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| io_addr | input | 8 | Low byte of the CPU address bus, used for port decode |
| data_in | input | 8 | CPU data bus as seen by the block |
| data_out | output | 8 | Byte the block places on the data bus |
| data_oe | output | 1 | Enable for the block's data bus driver |
| mem_inhibit | output | 1 | High while system memory must not drive read data |
| int_n | output | 1 | Interrupt request to the CPU, active low |

## Verification
The assertions check the following on every cycle:
- the CALL opcode is present throughout any acknowledge;
- the block drives the bus only during an acknowledge or a memory read;
- `mem_inhibit` rises only after an acknowledge and clears after an opcode fetch;
- INT stays quiet while a feed is in progress.

The ranking of requests, the handler address that each port write loads, the order of the operand bytes, the nesting of in-service sources, and the difference between a true return sequence and an 0xED followed by another opcode all depend on history. Only the bench's scenarios, compared against its reference model, can show those.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;

    localparam logic [7:0] OPC_CALL   = 8'hCD;
    localparam logic [7:0] OPC_PREFIX = 8'hED;
    localparam logic [7:0] OPC_RET_2  = 8'h4D;

    // Bus cycle kinds decoded from the Z80 strobes.
    typedef struct packed {
        logic ack;   // interrupt acknowledge
        logic opf;   // opcode fetch
        logic mrd;   // ordinary memory read
        logic iow;   // I/O write
    } strobe_t;

    function automatic strobe_t decode_strobes(
        input logic m1_n,
        input logic iorq_n,
        input logic mreq_n,
        input logic rd_n,
        input logic wr_n
    );
        strobe_t s;
        s.ack = !m1_n && !iorq_n;
        s.opf = !m1_n && !mreq_n;
        s.mrd =  m1_n && !mreq_n && !rd_n;
        s.iow =  m1_n && !iorq_n && !wr_n;
        return s;
    endfunction

endpackage

// File: rtl/ivc_prio_pick.sv
`timescale 1ns/1ps
// Finds the lowest set index of a request vector (index 0 wins).
module ivc_prio_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ivc_vector_bank.sv
`timescale 1ns/1ps
// One 16-bit handler address per source, loaded byte-wise through I/O ports.
module ivc_vector_bank #(
    parameter int          N         = 8,
    parameter logic [7:0]  PORT_BASE = 8'h40,
    parameter int          IW        = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_port,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] sel,
    output logic [15:0]   vec_out
);

    logic [15:0] vec_all [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        localparam logic [7:0] LO_PORT = 8'(PORT_BASE + 2 * g);
        localparam logic [7:0] HI_PORT = 8'(PORT_BASE + 2 * g + 1);

        logic [15:0] vec_d, vec_q;

        always_comb begin
            vec_d = vec_q;
            if (wr_en && wr_port == LO_PORT) vec_d[7:0]  = wr_data;
            if (wr_en && wr_port == HI_PORT) vec_d[15:8] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_d;
        end

        assign vec_all[g] = vec_q;
    end

    assign vec_out = vec_all[sel];

endmodule

// File: rtl/z80_im0_vic.sv
`timescale 1ns/1ps
module z80_im0_vic #(
    parameter int         N_SRC     = 8,
    parameter logic [7:0] PORT_BASE = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             mreq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [7:0]       io_addr,
    input  logic [7:0]       data_in,
    output logic [7:0]       data_out,
    output logic             data_oe,
    output logic             mem_inhibit,
    output logic             int_n
);
    import ivc_pkg::*;

    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    // Operand byte positions after the opcode.
    localparam logic [1:0] IDX_LO   = 2'd1;
    localparam logic [1:0] IDX_HI   = 2'd2;
    localparam logic [1:0] IDX_DONE = 2'd3;

    typedef struct packed {
        strobe_t          prev;
        logic             feeding;
        logic [1:0]       byte_idx;
        logic [IW-1:0]    src;
        logic [N_SRC-1:0] in_svc;
        logic             saw_ed;
        logic [7:0]       fetch_byte;
    } state_t;

    state_t  s_d, s_q;
    strobe_t now;
    logic    ack_start, opf_start, opf_end, mrd_end, iow_start;

    logic [N_SRC-1:0] eligible;
    logic             win_found, svc_found;
    logic [IW-1:0]    win_idx, svc_idx;
    logic [15:0]      vec_sel;

    // ---------------- bus cycle edges ----------------
    always_comb begin
        now       = decode_strobes(m1_n, iorq_n, mreq_n, rd_n, wr_n);
        ack_start = now.ack && !s_q.prev.ack;
        opf_start = now.opf && !s_q.prev.opf;
        opf_end   = !now.opf && s_q.prev.opf;
        mrd_end   = !now.mrd && s_q.prev.mrd;
        iow_start = now.iow && !s_q.prev.iow;
    end

    // ---------------- eligibility under in-service masking ----------------
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (s_q.in_svc[i]) blocked = 1'b1;
            eligible[i] = irq_req[i] && !blocked;
        end
    end

    ivc_prio_pick #(.N(N_SRC), .IW(IW)) u_pick_win (
        .req   (eligible),
        .found (win_found),
        .idx   (win_idx)
    );

    ivc_prio_pick #(.N(N_SRC), .IW(IW)) u_pick_svc (
        .req   (s_q.in_svc),
        .found (svc_found),
        .idx   (svc_idx)
    );

    ivc_vector_bank #(.N(N_SRC), .PORT_BASE(PORT_BASE), .IW(IW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (iow_start),
        .wr_port (io_addr),
        .wr_data (data_in),
        .sel     (s_q.src),
        .vec_out (vec_sel)
    );

    // ---------------- next state ----------------
    always_comb begin
        s_d      = s_q;
        s_d.prev = now;

        if (ack_start && !s_q.feeding) begin
            s_d.feeding  = 1'b1;
            s_d.byte_idx = IDX_LO;
            s_d.src      = win_idx;
            if (win_found) s_d.in_svc[win_idx] = 1'b1;
        end

        if (mrd_end && s_q.feeding && s_q.byte_idx != IDX_DONE)
            s_d.byte_idx = s_q.byte_idx + 2'd1;

        if (opf_start) s_d.feeding = 1'b0;

        if (now.opf) s_d.fetch_byte = data_in;

        if (opf_end) begin
            if (s_q.fetch_byte == OPC_PREFIX) begin
                s_d.saw_ed = 1'b1;
            end else begin
                if (s_q.saw_ed && s_q.fetch_byte == OPC_RET_2 && svc_found)
                    s_d.in_svc[svc_idx] = 1'b0;
                s_d.saw_ed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- outputs ----------------
    always_comb begin
        data_out = '0;
        data_oe  = 1'b0;
        if (now.ack) begin
            data_out = OPC_CALL;
            data_oe  = 1'b1;
        end else if (now.mrd && s_q.feeding) begin
            if (s_q.byte_idx == IDX_LO) begin
                data_out = vec_sel[7:0];
                data_oe  = 1'b1;
            end else if (s_q.byte_idx == IDX_HI) begin
                data_out = vec_sel[15:8];
                data_oe  = 1'b1;
            end
        end
    end

    assign mem_inhibit = s_q.feeding;
    assign int_n       = !(win_found && !s_q.feeding);

endmodule

// File: rtl/ivc_checker.sv
`timescale 1ns/1ps
module ivc_checker #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_req,
    input logic             m1_n,
    input logic             iorq_n,
    input logic             mreq_n,
    input logic             rd_n,
    input logic [7:0]       data_out,
    input logic             data_oe,
    input logic             mem_inhibit,
    input logic             int_n
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!mem_inhibit);
        end
    end

    assert_call_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n && !iorq_n) |-> (data_oe && data_out == 8'hCD));

    assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ((!m1_n && !iorq_n) || (!mreq_n && !rd_n)));

    assert_inhibit_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_inhibit) |-> $past(!m1_n && !iorq_n));

    assert_inhibit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n && !mreq_n && iorq_n) |=> !mem_inhibit);

    assert_quiet_feed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> int_n);

    assert_int_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> (|irq_req));

endmodule

bind z80_im0_vic ivc_checker #(.N_SRC(N_SRC)) u_ivc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .m1_n        (m1_n),
    .iorq_n      (iorq_n),
    .mreq_n      (mreq_n),
    .rd_n        (rd_n),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .mem_inhibit (mem_inhibit),
    .int_n       (int_n)
);

// File: tb/tb_z80_im0_vic.sv
`timescale 1ns/1ps
module tb_z80_im0_vic;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       m1_n = 1'b1, iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] io_addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe, mem_inhibit, int_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    z80_im0_vic dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .m1_n(m1_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .io_addr(io_addr), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe),
        .mem_inhibit(mem_inhibit), .int_n(int_n)
    );

    // ---------------- behavioural reference model ----------------
    int m_vec_lo [8];
    int m_vec_hi [8];
    bit m_svc [8];
    bit m_feed;
    int m_pos;
    int m_src;
    bit m_ed;
    int m_last;
    bit p_ack, p_opf, p_mrd, p_iow;

    function automatic int model_winner();
        for (int i = 0; i < 8; i++) begin
            if (m_svc[i]) return -1;
            if (irq_req[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_vec_lo[i] = 0; m_vec_hi[i] = 0; m_svc[i] = 0;
            end
            m_feed = 0; m_pos = 0; m_src = 0; m_ed = 0; m_last = 0;
            p_ack = 0; p_opf = 0; p_mrd = 0; p_iow = 0;
        end else begin
            bit ack, opf, mrd, iow;
            int w;
            ack = !m1_n && !iorq_n;
            opf = !m1_n && !mreq_n;
            mrd = m1_n && !mreq_n && !rd_n;
            iow = m1_n && !iorq_n && !wr_n;
            if (ack && !p_ack && !m_feed) begin
                w = model_winner();
                m_feed = 1; m_pos = 1;
                m_src = (w < 0) ? 0 : w;
                if (w >= 0) m_svc[w] = 1;
            end
            if (!mrd && p_mrd && m_feed && m_pos < 3) m_pos++;
            if (opf && !p_opf) m_feed = 0;
            if (iow && !p_iow) begin
                int off;
                off = int'(io_addr) - 'h40;
                if (off >= 0 && off < 16) begin
                    if (off % 2 == 0) m_vec_lo[off / 2] = int'(data_in);
                    else              m_vec_hi[off / 2] = int'(data_in);
                end
            end
            if (!opf && p_opf) begin
                if (m_last == 'hED) m_ed = 1;
                else begin
                    if (m_ed && m_last == 'h4D) begin
                        for (int i = 0; i < 8; i++)
                            if (m_svc[i]) begin m_svc[i] = 0; break; end
                    end
                    m_ed = 0;
                end
            end
            if (opf) m_last = int'(data_in);
            p_ack = ack; p_opf = opf; p_mrd = mrd; p_iow = iow;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_int, e_oe, e_dat, w;
            bit ack, mrd;
            ack = !m1_n && !iorq_n;
            mrd = m1_n && !mreq_n && !rd_n;
            w = model_winner();
            e_int = (!m_feed && w >= 0) ? 0 : 1;
            e_oe = 0; e_dat = 0;
            if (ack) begin e_oe = 1; e_dat = 'hCD; end
            else if (mrd && m_feed && m_pos == 1) begin e_oe = 1; e_dat = m_vec_lo[m_src]; end
            else if (mrd && m_feed && m_pos == 2) begin e_oe = 1; e_dat = m_vec_hi[m_src]; end
            check("R2 model int_n", int'(int_n), e_int);
            check("R6 model mem_inhibit", int'(mem_inhibit), int'(m_feed));
            check(ack ? "R4 model data_oe" : "R5 model data_oe", int'(data_oe), e_oe);
            if (e_oe == 1) check(ack ? "R4 model data" : "R5 model data", int'(data_out), e_dat);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus(input bit m1, input bit iorq, input bit mreq, input bit rd, input bit wr,
                       input logic [7:0] a, input logic [7:0] d,
                       output logic [7:0] b, output logic oe);
        m1_n = m1; iorq_n = iorq; mreq_n = mreq; rd_n = rd; wr_n = wr;
        io_addr = a; data_in = d;
        @(negedge clk); b = data_out; oe = data_oe;
        repeat (2) @(posedge clk);
        #1;
        m1_n = 1; iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1;
        @(posedge clk); #1;
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] v);
        logic [7:0] b; logic oe;
        bus(1, 0, 1, 1, 0, port, v, b, oe);
    endtask

    task automatic ack_cycle(output logic [7:0] b, output logic oe);
        bus(0, 0, 1, 1, 1, 8'h00, 8'h00, b, oe);
    endtask

    task automatic mem_read(output logic [7:0] b, output logic oe);
        bus(1, 1, 0, 0, 1, 8'h00, 8'h00, b, oe);
    endtask

    task automatic op_fetch(input logic [7:0] opc);
        logic [7:0] b; logic oe;
        bus(0, 1, 0, 0, 1, 8'h00, opc, b, oe);
    endtask

    task automatic sample_int(input string tag, input int exp);
        @(negedge clk);
        check(tag, int'(int_n), exp);
        @(posedge clk); #1;
    endtask

    // Full service: acknowledge, two operand reads, then next opcode fetch.
    task automatic serve(input string tag, input int exp_lo, input int exp_hi);
        logic [7:0] b; logic oe;
        ack_cycle(b, oe);
        check({tag, " opcode"}, int'(b), 'hCD);
        mem_read(b, oe);
        check({tag, " low"}, int'(b), exp_lo);
        mem_read(b, oe);
        check({tag, " high"}, int'(b), exp_hi);
        op_fetch(8'h00);
    endtask

    function automatic int vlo(input int i); return 'h05 + 16 * i; endfunction
    function automatic int vhi(input int i); return 'hA0 + i; endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] b; logic oe;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check("R1 reset int_n", int'(int_n), 1);
        check("R1 reset mem_inhibit", int'(mem_inhibit), 0);
        check("R1 reset data_oe", int'(data_oe), 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R7: load all handler addresses, high byte first for odd sources
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 1) io_write(8'(8'h41 + 2 * i), 8'(vhi(i)));
            io_write(8'(8'h40 + 2 * i), 8'(vlo(i)));
            if (i % 2 == 0) io_write(8'(8'h41 + 2 * i), 8'(vhi(i)));
        end
        sample_int("R1 no request keeps int_n high", 1);

        // Single request on source 5
        irq_req = 8'b0010_0000;
        sample_int("R2 request raises INT", 0);
        ack_cycle(b, oe);
        check("R4 ack drives CALL", int'(b), 'hCD);
        check("R4 ack drive enable", int'(oe), 1);
        @(negedge clk);
        check("R6 inhibit after ack", int'(mem_inhibit), 1);
        check("R2 no INT during feed", int'(int_n), 1);
        @(posedge clk); #1;
        irq_req = 8'b0010_0010;   // R10: higher request arrives mid-feed
        mem_read(b, oe);
        check("R10 low byte of latched source", int'(b), vlo(5));
        mem_read(b, oe);
        check("R10 high byte of latched source", int'(b), vhi(5));
        mem_read(b, oe);
        check("R5 third read not driven", int'(oe), 0);
        op_fetch(8'h00);
        @(negedge clk);
        check("R6 inhibit cleared by fetch", int'(mem_inhibit), 0);
        @(posedge clk); #1;

        // R8: higher priority may nest
        sample_int("R8 higher source interrupts", 0);
        serve("R3 nested source 1", vlo(1), vhi(1));
        irq_req = 8'b0010_0000;
        sample_int("R8 in-service blocks own level", 1);

        // R9: ED followed by other opcode is not a return
        op_fetch(8'hED); op_fetch(8'h00);
        irq_req = 8'b0010_1000;
        sample_int("R9 ED then 00 retires nothing", 1);
        op_fetch(8'hED); op_fetch(8'h4D);
        sample_int("R9 return retires source 1", 0);
        irq_req = 8'b0010_0000;
        sample_int("R9 source 5 still in service", 1);
        op_fetch(8'hED); op_fetch(8'h4D);
        sample_int("R9 return retires source 5", 0);

        // R3: several at once
        irq_req = 8'b1110_0100;
        serve("R3 priority picks source 2", vlo(2), vhi(2));
        sample_int("R8 lower sources blocked", 1);

        // R7: rewrite single bytes
        io_write(8'h44, 8'h9C);
        io_write(8'h4F, 8'h3B);
        op_fetch(8'hED); op_fetch(8'h4D);
        irq_req = 8'b1000_0000;
        serve("R7 source 7 new high byte", vlo(7), 'h3B);
        irq_req = 8'b0000_0100;
        serve("R7 source 2 new low byte", 'h9C, vhi(2));
        irq_req = '0;
        repeat (2) @(posedge clk);
        #1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule